// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a short global record of the directions of the most recent resolved branches. It also keeps a table of two-bit saturating counters. A few low instruction-address bits pick a row of the table, and the global record picks one counter inside that row. The fetch stage presents an address and reads back a taken/not-taken guess in the same cycle. Later, the execute or decode stage reports the real outcome of a branch. Only the counter chosen by that branch's row and the current global record moves, and the outcome is then shifted into the record.

Each counter is a four-state machine with hysteresis. The states and their encodings are `CTR_STRONG_T` (01), `CTR_WEAK_T` (00), `CTR_WEAK_N` (11) and `CTR_STRONG_N` (10). The transitions are:
- **promote**: a taken outcome moves one step towards `CTR_STRONG_T` (10→11→00→01).
- **demote**: a not-taken outcome moves one step back towards `CTR_STRONG_N`.
- **hold**: no update, or saturation at either end, leaves the state unchanged.

A single wrong outcome from a strong state therefore does not change the guess. Setting the history length to zero turns the block into a plain per-address table of two-bit counters.

Top module: `corr_bpred`

## Requirements
- R1: After reset every counter is in state 11 (weakly not-taken) and the global history is all zeros, so every lookup returns not-taken.
- R2: The row is taken from address bits [ROW_BITS+1:2] (bits [5:2] by default). Bits [1:0] and all bits above the row field have no effect on the prediction.
- R3: On each cycle with `up_valid` high, the history shifts left one place and `up_taken` enters at bit 0, so bit 0 is the newest outcome. The counter used is number {row, history}, with the history as the low bits.
- R4: An update changes at most one counter: the one at {row of `up_pc`, history before the shift}.
- R5: A taken outcome moves the counter 10→11→00→01 and holds it at 01. A not-taken outcome moves it 01→00→11→10 and holds it at 10.
- R6: `lk_taken` is 1 when the selected counter is 01 or 00, and 0 when it is 11 or 10.
- R7: From a strong state (01 or 10), a single opposite outcome leaves the prediction of that counter unchanged.
- R8: The lookup is combinational from the current state. A lookup in the same cycle as an update sees the state from before that update.
- R9: With `up_valid` low, `up_pc` and `up_taken` change neither the counters nor the history.
- R10: With HIST_BITS = 0, the block keeps one counter per row and no history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Fetch address to predict |
| up_valid | input | 1 | A branch outcome is reported this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual direction of the resolved branch |
| lk_taken | output | 1 | Predicted direction for `lk_pc` |

## Verification
A wrong counter or history bit can stay hidden until a lookup reaches exactly that {row, history} slot. At that point it shows as a flipped `lk_taken` in the same cycle. A history that shifts wrongly does more damage: from the next cycle it moves every later lookup and update onto a different column, and the misprediction pattern spreads across rows. The bench therefore compares `lk_taken` against a reference table on every cycle, for both the correlating and the zero-history builds, so such a fault shows within the first lookup that touches the damaged state.

// File: rtl/bp_corr_pkg.sv
package bp_corr_pkg;

    // Two-bit counter states; the MSB set means "predict not-taken".
    typedef enum logic [1:0] {
        CTR_WEAK_T   = 2'b00,
        CTR_STRONG_T = 2'b01,
        CTR_STRONG_N = 2'b10,
        CTR_WEAK_N   = 2'b11
    } ctr_state_t;

endpackage

// File: rtl/bp_ghist.sv
module bp_ghist #(
    parameter int HIST_BITS = 2,
    localparam int HIST_W = (HIST_BITS > 0) ? HIST_BITS : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              outcome,
    output logic [HIST_W-1:0] hist_o
);

    generate
        if (HIST_BITS > 0) begin : g_hist
            logic [HIST_W-1:0] hist_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    hist_q <= '0;
                end else if (shift_en) begin
                    hist_q <= HIST_W'({hist_q, outcome});
                end
            end

            assign hist_o = hist_q;
        end else begin : g_nohist
            logic in_unused;
            assign in_unused = ^{clk, rst_n, shift_en, outcome};
            assign hist_o    = '0;
        end
    endgenerate

endmodule

// File: rtl/bp_index.sv
module bp_index #(
    parameter int ROW_BITS  = 4,
    parameter int HIST_BITS = 2,
    localparam int HIST_W = (HIST_BITS > 0) ? HIST_BITS : 1,
    localparam int IDX_W  = ROW_BITS + HIST_BITS
) (
    input  logic [ROW_BITS-1:0] row,
    input  logic [HIST_W-1:0]   hist,
    output logic [IDX_W-1:0]    idx
);

    generate
        if (HIST_BITS > 0) begin : g_corr
            assign idx = {row, hist};
        end else begin : g_local
            logic hist_unused;
            assign hist_unused = ^hist;
            assign idx         = row;
        end
    endgenerate

endmodule

// File: rtl/bp_ctr_cell.sv
module bp_ctr_cell
    import bp_corr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_en,
    input  logic       outcome,
    output ctr_state_t state_o,
    output logic       pred_o
);

    ctr_state_t state_q;
    ctr_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CTR_WEAK_N;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: promote on taken, demote on not-taken, hold otherwise
    always_comb begin
        state_d = state_q;
        if (upd_en) begin
            unique case (state_q)
                CTR_STRONG_N: state_d = outcome ? CTR_WEAK_N   : CTR_STRONG_N;
                CTR_WEAK_N:   state_d = outcome ? CTR_WEAK_T   : CTR_STRONG_N;
                CTR_WEAK_T:   state_d = outcome ? CTR_STRONG_T : CTR_WEAK_N;
                CTR_STRONG_T: state_d = outcome ? CTR_STRONG_T : CTR_WEAK_T;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            CTR_STRONG_T, CTR_WEAK_T: pred_o = 1'b1;
            CTR_WEAK_N, CTR_STRONG_N: pred_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
    import bp_corr_pkg::*;
#(
    parameter int IDX_W = 6,
    localparam int NUM_CTR = 1 << IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     rd_idx,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic                 wr_taken,
    output logic                 rd_pred,
    output logic [2*NUM_CTR-1:0] ctr_flat
);

    logic [NUM_CTR-1:0] pred_vec;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_cell
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        ctr_state_t st;

        bp_ctr_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_en  (wr_en && (wr_idx == MY_IDX)),
            .outcome (wr_taken),
            .state_o (st),
            .pred_o  (pred_vec[i])
        );

        assign ctr_flat[2*i +: 2] = st;
    end

    assign rd_pred = pred_vec[rd_idx];

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
    parameter int PC_W      = 32,
    parameter int ROW_BITS  = 4,
    parameter int HIST_BITS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    output logic            lk_taken
);

    localparam int HIST_W  = (HIST_BITS > 0) ? HIST_BITS : 1;
    localparam int IDX_W   = ROW_BITS + HIST_BITS;
    localparam int NUM_CTR = 1 << IDX_W;
    localparam int ROW_LO  = 2;
    localparam int ROW_HI  = ROW_LO + ROW_BITS - 1;

    logic [HIST_W-1:0]    ghist;
    logic [IDX_W-1:0]     lk_idx;
    logic [IDX_W-1:0]     upd_idx;
    logic [2*NUM_CTR-1:0] ctr_flat;
    logic                 pc_unused;

    // The byte offset and the bits above the row field do not take part
    assign pc_unused = ^{lk_pc[PC_W-1:ROW_HI+1], lk_pc[ROW_LO-1:0],
                         up_pc[PC_W-1:ROW_HI+1], up_pc[ROW_LO-1:0]};

    bp_ghist #(.HIST_BITS(HIST_BITS)) u_ghist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (up_valid),
        .outcome  (up_taken),
        .hist_o   (ghist)
    );

    bp_index #(.ROW_BITS(ROW_BITS), .HIST_BITS(HIST_BITS)) u_lk_index (
        .row  (lk_pc[ROW_HI:ROW_LO]),
        .hist (ghist),
        .idx  (lk_idx)
    );

    bp_index #(.ROW_BITS(ROW_BITS), .HIST_BITS(HIST_BITS)) u_up_index (
        .row  (up_pc[ROW_HI:ROW_LO]),
        .hist (ghist),
        .idx  (upd_idx)
    );

    bp_ctr_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .wr_en    (up_valid),
        .wr_idx   (upd_idx),
        .wr_taken (up_taken),
        .rd_pred  (lk_taken),
        .ctr_flat (ctr_flat)
    );

endmodule

// File: rtl/corr_bpred_chk.sv
module corr_bpred_chk #(
    parameter int ROW_BITS  = 4,
    parameter int HIST_BITS = 2,
    localparam int HIST_W  = (HIST_BITS > 0) ? HIST_BITS : 1,
    localparam int IDX_W   = ROW_BITS + HIST_BITS,
    localparam int NUM_CTR = 1 << IDX_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 up_valid,
    input logic                 up_taken,
    input logic [HIST_W-1:0]    ghist,
    input logic [IDX_W-1:0]     upd_idx,
    input logic [2*NUM_CTR-1:0] ctr_flat
);

    logic [2*NUM_CTR-1:0] prev_flat;
    logic                 vld_q;
    logic                 taken_q;
    logic [IDX_W-1:0]     idx_q;
    logic [NUM_CTR-1:0]   chg;
    logic [NUM_CTR-1:0]   sel_mask;
    logic [1:0]           prev_sel;
    logic [1:0]           cur_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_flat <= {NUM_CTR{2'b11}};
            vld_q     <= 1'b0;
            taken_q   <= 1'b0;
            idx_q     <= '0;
        end else begin
            prev_flat <= ctr_flat;
            vld_q     <= up_valid;
            taken_q   <= up_taken;
            idx_q     <= upd_idx;
        end
    end

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_chg
        assign chg[i] = (ctr_flat[2*i +: 2] != prev_flat[2*i +: 2]);
    end

    assign sel_mask = NUM_CTR'(1) << idx_q;
    assign prev_sel = prev_flat[2*idx_q +: 2];
    assign cur_sel  = ctr_flat[2*idx_q +: 2];

    // R4
    one_ctr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg & ~sel_mask) == '0);

    // R9
    idle_ctr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_q |-> chg == '0);

    // R7
    hyst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && (prev_sel == 2'b01 || prev_sel == 2'b10)) |-> cur_sel[1] == prev_sel[1]);

    // R5
    sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && taken_q && prev_sel == 2'b01) |-> cur_sel == 2'b01);

    // R5
    sat_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !taken_q && prev_sel == 2'b10) |-> cur_sel == 2'b10);

    generate
        if (HIST_BITS > 0) begin : g_hist_chk
            // R3
            hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                up_valid |=> ghist == HIST_W'({$past(ghist), $past(up_taken)}));

            // R9
            hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !up_valid |=> $stable(ghist));
        end
    endgenerate

endmodule

bind corr_bpred corr_bpred_chk #(
    .ROW_BITS  (ROW_BITS),
    .HIST_BITS (HIST_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (up_valid),
    .up_taken (up_taken),
    .ghist    (ghist),
    .upd_idx  (upd_idx),
    .ctr_flat (ctr_flat)
);

// File: tb/corr_bpred_tb.sv
module corr_bpred_tb;

    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic            up_valid = 1'b0;
    logic [PC_W-1:0] up_pc = '0;
    logic            up_taken = 1'b0;
    logic            lk_taken;
    logic            lk_taken0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference state: correlating build (64 counters) and zero-history build (16)
    logic [1:0] m_ctr [64];
    logic [1:0] m0_ctr[16];
    logic [1:0] m_hist;

    always #10 clk = ~clk;

    corr_bpred #(.PC_W(PC_W), .ROW_BITS(4), .HIST_BITS(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .up_valid(up_valid),
        .up_pc(up_pc), .up_taken(up_taken), .lk_taken(lk_taken));

    corr_bpred #(.PC_W(PC_W), .ROW_BITS(4), .HIST_BITS(0)) u_dut_k0 (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .up_valid(up_valid),
        .up_pc(up_pc), .up_taken(up_taken), .lk_taken(lk_taken0));

    function automatic logic [1:0] f_next(logic [1:0] s, logic t);
        case (s)
            2'b10:   return t ? 2'b11 : 2'b10;
            2'b11:   return t ? 2'b00 : 2'b10;
            2'b00:   return t ? 2'b01 : 2'b11;
            default: return t ? 2'b01 : 2'b00;
        endcase
    endfunction

    function automatic logic f_pred(logic [1:0] s);
        return ~s[1];
    endfunction

    function automatic logic [3:0] f_row(logic [PC_W-1:0] pc);
        return pc[5:2];
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check lookup before the edge, update model at the edge.
    task automatic step(string tag, logic [PC_W-1:0] lpc, logic v,
                        logic [PC_W-1:0] upc, logic t);
        @(negedge clk);
        lk_pc = lpc; up_valid = v; up_pc = upc; up_taken = t;
        #2;
        check(tag, lk_taken, f_pred(m_ctr[{f_row(lpc), m_hist}]));
        check("R10 zero-history build", lk_taken0, f_pred(m0_ctr[f_row(lpc)]));
        @(posedge clk);
        if (v) begin
            m_ctr[{f_row(upc), m_hist}] = f_next(m_ctr[{f_row(upc), m_hist}], t);
            m0_ctr[f_row(upc)]          = f_next(m0_ctr[f_row(upc)], t);
            m_hist                      = {m_hist[0], t};
        end
    endtask

    function automatic logic [PC_W-1:0] mk_pc(logic [3:0] row);
        return {$urandom(), row, 2'($urandom())} & {PC_W{1'b1}};
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        foreach (m_ctr[i]) m_ctr[i] = 2'b11;
        foreach (m0_ctr[i]) m0_ctr[i] = 2'b11;
        m_hist = 2'b00;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every row predicts not-taken after reset
        for (int r = 0; r < 16; r++) begin
            step("R1 reset state", mk_pc(4'(r)), 1'b0, '0, 1'b0);
            check("R1 literal", lk_taken, 1'b0);
        end

        // R5/R6: promote row 3 at history 00 by one step -> 00 predicts taken
        step("R5 promote", mk_pc(4'd3), 1'b1, mk_pc(4'd3), 1'b1);   // hist -> 01
        step("R3 shift", mk_pc(4'd3), 1'b1, mk_pc(4'd7), 1'b0);     // hist -> 10
        step("R3 shift", mk_pc(4'd3), 1'b1, mk_pc(4'd7), 1'b0);     // hist -> 00
        step("R6 weak taken", mk_pc(4'd3), 1'b0, '0, 1'b0);
        check("R6 literal", lk_taken, 1'b1);

        // R2: byte offset and high bits do not matter
        step("R2 offset 1", 32'hFFFF_FF0D, 1'b0, '0, 1'b1);
        check("R2 literal", lk_taken, 1'b1);
        step("R2 offset 2", 32'h0000_000E, 1'b0, '0, 1'b1);
        check("R2 literal", lk_taken, 1'b1);

        // R7: build strong taken at row 5 / history 11, one not-taken keeps taken
        step("R3 prep", mk_pc(4'd9), 1'b1, mk_pc(4'd9), 1'b1);
        step("R3 prep", mk_pc(4'd9), 1'b1, mk_pc(4'd9), 1'b1);      // hist 11
        for (int j = 0; j < 3; j++)
            step("R5 saturate up", mk_pc(4'd5), 1'b1, mk_pc(4'd5), 1'b1);
        step("R7 one miss", mk_pc(4'd5), 1'b1, mk_pc(4'd5), 1'b0);  // hist 10
        step("R3 prep", mk_pc(4'd9), 1'b1, mk_pc(4'd9), 1'b1);      // hist 01
        step("R3 prep", mk_pc(4'd9), 1'b1, mk_pc(4'd9), 1'b1);      // hist 11
        step("R7 hysteresis", mk_pc(4'd5), 1'b0, '0, 1'b0);
        check("R7 literal", lk_taken, 1'b1);

        // R8: same-cycle update and lookup of one counter sees old state
        step("R8 pre-update", mk_pc(4'd5), 1'b1, mk_pc(4'd5), 1'b0);

        // R4/R5: drive row 12 down to saturation, others untouched
        for (int j = 0; j < 4; j++)
            step("R5 saturate down", mk_pc(4'd12), 1'b1, mk_pc(4'd12), 1'b0);
        for (int r = 0; r < 16; r++)
            step("R4 single counter", mk_pc(4'(r)), 1'b0, '0, 1'b0);

        // R9 idle cycles with noise on the update inputs
        for (int j = 0; j < 40; j++)
            step("R9 idle update", mk_pc(4'($urandom_range(0, 15))), 1'b0,
                 mk_pc(4'($urandom_range(0, 15))), 1'($urandom()));

        // Random mix: few rows, biased outcomes, gaps in valid
        for (int j = 0; j < 3000; j++) begin
            logic [3:0] lr;
            logic [3:0] ur;
            lr = 4'($urandom_range(0, 5));
            ur = 4'($urandom_range(0, 5));
            step("R3 random mix", mk_pc(lr), ($urandom_range(0, 3) != 0),
                 mk_pc(ur), (($urandom_range(0, 9) < 32'(ur) + 2)));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule